// File: doc/BRIEF.md
# Video Frame Timing and Event Sequencer

This block produces the raster timebase of a video subsystem. A horizontal counter steps once per master clock through a scanline of 341 dots of 4 cycles each. A vertical counter steps once per line and wraps once per field. Combinational decodes of the two counters give single-cycle strobes at fixed, parameterised positions on the line:

- hblank start
- the per-line DMA trigger
- line end
- the frame DMA initialisation
- the render latch
- the memory refresh slot

A refresh stall output covers the refresh slot.

The block keeps three pieces of field state: an odd/even field bit, a vertical blank flag and a level NMI request. It also emits an auto-joypad start pulse a few lines into vertical blank. Four control levels shape the timing:

- the interlace enable changes both the number of lines in a field and the shortening of one line;
- the overscan select picks 224 or 239 visible lines;
- the NMI enable decides whether entering vertical blank raises an NMI;
- the auto-joypad enable gates the joypad pulse.

All pins are plain control and status levels. No data stream passes through the block. The control inputs are sampled every cycle, and a consumer is expected to change them only at field boundaries.

Top module: `ft_frame_timer`

## Requirements
- R1: The horizontal counter counts 0 up to line length minus 1 and then returns to 0. `line_end_o` is high in exactly the last cycle of each line, and the vertical counter advances on that cycle.
- R2: With `ilace_i` low, a field has LINES lines (vertical counter 0..LINES-1). With `ilace_i` high, a field whose field bit is 0 has LINES+1 lines and a field whose field bit is 1 has LINES lines.
- R3: `field_o` inverts exactly when the vertical counter wraps to 0, and at no other time.
- R4: With `ilace_i` low and `field_o` at 1, line SHORT_LINE lasts LINE_CYC-DOT_CYC cycles. Every other line, and every line while `ilace_i` is high, lasts LINE_CYC cycles.
- R5: The refresh position is REF_A on line 0 after reset. It swaps between REF_A and REF_B at every new line, except that a line entered as the short line of R4 keeps the position of the line before it. `refresh_o` is high for one cycle at that position.
- R6: `stall_o` is high for exactly REF_LEN consecutive cycles, starting in the cycle where `refresh_o` is high.
- R7: The visible height is 224 when `overscan_i`=0 and 239 when `overscan_i`=1. `vblank_o` rises in the first cycle of line height+1 and falls in the first cycle of line 0. `dma_clear_o` pulses in the first cycle of line height+1.
- R8: If `nmi_en_i` is high on the last cycle before line height+1, `nmi_o` rises in the cycle where the horizontal counter equals NMI_DELAY on that line and holds until line 0 begins. Otherwise `nmi_o` stays low for that field.
- R9: `frame_init_o` pulses only on line 0, at horizontal position INIT_POS.
- R10: `joy_start_o` pulses in the first cycle of line height+3 when `joy_en_i` is high, and never when it is low.
- R11: `hblank_o` pulses at HBLANK_POS on every line. `line_dma_o` pulses at LINE_DMA_POS on lines 0..height. `render_o` pulses at RENDER_POS on lines 1..height.
- R12: While reset is low, both counters are 0 and `field_o`, `vblank_o` and `nmi_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | master clock |
| rst_n | input | 1 | active-low synchronous reset |
| ilace_i | input | 1 | interlace enable |
| overscan_i | input | 1 | 0: 224 visible lines, 1: 239 |
| nmi_en_i | input | 1 | allow NMI at vertical blank |
| joy_en_i | input | 1 | allow auto-joypad start pulse |
| h_cnt_o | output | HW = clog2(LINE_CYC) | horizontal cycle counter |
| v_cnt_o | output | VW = clog2(LINES+1) | vertical line counter |
| hblank_o | output | 1 | hblank start strobe |
| line_dma_o | output | 1 | per-line DMA trigger strobe |
| line_end_o | output | 1 | last cycle of the line |
| frame_init_o | output | 1 | frame DMA initialisation strobe |
| render_o | output | 1 | render latch strobe |
| refresh_o | output | 1 | refresh slot start strobe |
| stall_o | output | 1 | refresh stall level |
| dma_clear_o | output | 1 | clear per-line DMA enables (vblank entry) |
| joy_start_o | output | 1 | auto-joypad start pulse |
| vblank_o | output | 1 | vertical blank flag |
| field_o | output | 1 | field bit |
| nmi_o | output | 1 | NMI request level |

## Verification
Every strobe and the stall level are decoded without registers from the counters. Each is therefore due in the same cycle as the counter value it names. The counters, the field bit and the vblank flag move on the clock edge that ends a line. The NMI level is registered one cycle early, so it shows up in the cycle whose horizontal count equals NMI_DELAY. The bench applies new control levels just after the falling edge and compares every output against its own line and field model in that same half cycle. It then steps the model once per rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/ft_pkg.sv
package ft_pkg;

  // Single-cycle event strobes decoded from the raster counters.
  typedef struct packed {
    logic hblank;
    logic line_dma;
    logic line_end;
    logic frame_init;
    logic render;
    logic refresh;
    logic stall;
    logic dma_clear;
    logic joy_start;
  } ft_strobe_t;

endpackage

// File: rtl/ft_hcount.sv
module ft_hcount #(
  parameter int HW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] len_m1,
  output logic [HW-1:0] h,
  output logic          last
);

  assign last = (h == len_m1);

  always_ff @(posedge clk) begin
    if (!rst_n)    h <= '0;
    else if (last) h <= '0;
    else           h <= h + HW'(1);
  end

endmodule

// File: rtl/ft_vcount.sv
module ft_vcount #(
  parameter int LINES      = 262,
  parameter int SHORT_LINE = 240,
  parameter int VW         = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_last,
  input  logic          ilace,
  output logic [VW-1:0] v,
  output logic [VW-1:0] v_nx,
  output logic          wrap,
  output logic          field,
  output logic          ref_phase,
  output logic          short_line
);

  logic [VW-1:0] last_line;
  logic          field_nx;
  logic          short_nx;

  always_comb begin
    // the field with field bit 0 is one line longer under interlace
    last_line  = (ilace && !field) ? VW'(LINES) : VW'(LINES - 1);
    wrap       = (v == last_line);
    v_nx       = wrap ? '0 : v + VW'(1);
    field_nx   = field ^ wrap;
    short_nx   = !ilace && field_nx && (v_nx == VW'(SHORT_LINE));
    short_line = !ilace && field && (v == VW'(SHORT_LINE));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v         <= '0;
      field     <= 1'b0;
      ref_phase <= 1'b0;
    end else if (line_last) begin
      v     <= v_nx;
      field <= field_nx;
      if (!short_nx) ref_phase <= ~ref_phase;
    end
  end

endmodule

// File: rtl/ft_events.sv
module ft_events
  import ft_pkg::*;
#(
  parameter int HBLANK_POS   = 1096,
  parameter int LINE_DMA_POS = 1106,
  parameter int INIT_POS     = 20,
  parameter int RENDER_POS   = 48,
  parameter int REF_A        = 534,
  parameter int REF_B        = 538,
  parameter int REF_LEN      = 40,
  parameter int HW           = 11,
  parameter int VW           = 9
) (
  input  logic [HW-1:0] h,
  input  logic [VW-1:0] v,
  input  logic [VW-1:0] vis,
  input  logic          ref_phase,
  input  logic          line_last,
  input  logic          joy_en,
  output ft_strobe_t    st
);

  logic [HW:0] ref_lo;
  logic [HW:0] ref_hi;
  logic [HW:0] h_ext;
  logic        line_top;

  always_comb begin
    ref_lo   = ref_phase ? (HW+1)'(REF_B) : (HW+1)'(REF_A);
    ref_hi   = ref_lo + (HW+1)'(REF_LEN);
    h_ext    = {1'b0, h};
    line_top = (h == '0);

    st.hblank     = (h == HW'(HBLANK_POS));
    st.line_dma   = (h == HW'(LINE_DMA_POS)) && (v <= vis);
    st.line_end   = line_last;
    st.frame_init = (h == HW'(INIT_POS)) && (v == '0);
    st.render     = (h == HW'(RENDER_POS)) && (v != '0) && (v <= vis);
    st.refresh    = (h_ext == ref_lo);
    st.stall      = (h_ext >= ref_lo) && (h_ext < ref_hi);
    st.dma_clear  = line_top && (v == vis + VW'(1));
    st.joy_start  = line_top && joy_en && (v == vis + VW'(3));
  end

endmodule

// File: rtl/ft_vblank.sv
module ft_vblank #(
  parameter int NMI_DELAY = 12,
  parameter int HW        = 11,
  parameter int VW        = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_last,
  input  logic          wrap,
  input  logic [VW-1:0] v,
  input  logic [VW-1:0] v_nx,
  input  logic [HW-1:0] h,
  input  logic [VW-1:0] vis,
  input  logic          nmi_en,
  output logic          vblank,
  output logic          nmi
);

  logic [VW-1:0] vbl_line;
  logic          armed;

  assign vbl_line = vis + VW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vblank <= 1'b0;
      nmi    <= 1'b0;
      armed  <= 1'b0;
    end else if (line_last && wrap) begin
      vblank <= 1'b0;
      nmi    <= 1'b0;
      armed  <= 1'b0;
    end else if (line_last && (v_nx == vbl_line)) begin
      vblank <= 1'b1;
      armed  <= nmi_en;
    end else if (armed && (v == vbl_line) && (h == HW'(NMI_DELAY - 1))) begin
      // registered one cycle early so the level is seen at NMI_DELAY
      nmi   <= 1'b1;
      armed <= 1'b0;
    end
  end

endmodule

// File: rtl/ft_frame_timer.sv
module ft_frame_timer
  import ft_pkg::*;
#(
  parameter int LINE_CYC     = 1364,
  parameter int DOT_CYC      = 4,
  parameter int LINES        = 262,
  parameter int VIS_LO       = 224,
  parameter int VIS_HI       = 239,
  parameter int SHORT_LINE   = 240,
  parameter int HBLANK_POS   = 1096,
  parameter int LINE_DMA_POS = 1106,
  parameter int INIT_POS     = 20,
  parameter int RENDER_POS   = 48,
  parameter int REF_A        = 534,
  parameter int REF_B        = 538,
  parameter int REF_LEN      = 40,
  parameter int NMI_DELAY    = 12,
  localparam int HW          = $clog2(LINE_CYC),
  localparam int VW          = $clog2(LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ilace_i,
  input  logic          overscan_i,
  input  logic          nmi_en_i,
  input  logic          joy_en_i,
  output logic [HW-1:0] h_cnt_o,
  output logic [VW-1:0] v_cnt_o,
  output logic          hblank_o,
  output logic          line_dma_o,
  output logic          line_end_o,
  output logic          frame_init_o,
  output logic          render_o,
  output logic          refresh_o,
  output logic          stall_o,
  output logic          dma_clear_o,
  output logic          joy_start_o,
  output logic          vblank_o,
  output logic          field_o,
  output logic          nmi_o
);

  localparam logic [HW-1:0] FULL_M1  = HW'(LINE_CYC - 1);
  localparam logic [HW-1:0] SHORT_M1 = HW'(LINE_CYC - DOT_CYC - 1);

  logic [HW-1:0] h;
  logic [HW-1:0] len_m1;
  logic          line_last;
  logic [VW-1:0] v;
  logic [VW-1:0] v_nx;
  logic          wrap;
  logic          field;
  logic          ref_phase;
  logic          short_line;
  logic [VW-1:0] vis;
  ft_strobe_t    st;

  assign vis    = overscan_i ? VW'(VIS_HI) : VW'(VIS_LO);
  assign len_m1 = short_line ? SHORT_M1 : FULL_M1;

  ft_hcount #(.HW(HW)) u_hcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .len_m1(len_m1),
    .h     (h),
    .last  (line_last)
  );

  ft_vcount #(.LINES(LINES), .SHORT_LINE(SHORT_LINE), .VW(VW)) u_vcnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_last (line_last),
    .ilace     (ilace_i),
    .v         (v),
    .v_nx      (v_nx),
    .wrap      (wrap),
    .field     (field),
    .ref_phase (ref_phase),
    .short_line(short_line)
  );

  ft_events #(
    .HBLANK_POS(HBLANK_POS), .LINE_DMA_POS(LINE_DMA_POS), .INIT_POS(INIT_POS),
    .RENDER_POS(RENDER_POS), .REF_A(REF_A), .REF_B(REF_B), .REF_LEN(REF_LEN),
    .HW(HW), .VW(VW)
  ) u_evt (
    .h        (h),
    .v        (v),
    .vis      (vis),
    .ref_phase(ref_phase),
    .line_last(line_last),
    .joy_en   (joy_en_i),
    .st       (st)
  );

  ft_vblank #(.NMI_DELAY(NMI_DELAY), .HW(HW), .VW(VW)) u_vbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_last(line_last),
    .wrap     (wrap),
    .v        (v),
    .v_nx     (v_nx),
    .h        (h),
    .vis      (vis),
    .nmi_en   (nmi_en_i),
    .vblank   (vblank_o),
    .nmi      (nmi_o)
  );

  assign h_cnt_o      = h;
  assign v_cnt_o      = v;
  assign field_o      = field;
  assign hblank_o     = st.hblank;
  assign line_dma_o   = st.line_dma;
  assign line_end_o   = st.line_end;
  assign frame_init_o = st.frame_init;
  assign render_o     = st.render;
  assign refresh_o    = st.refresh;
  assign stall_o      = st.stall;
  assign dma_clear_o  = st.dma_clear;
  assign joy_start_o  = st.joy_start;

endmodule

// File: rtl/ft_frame_timer_chk.sv
module ft_frame_timer_chk #(
  parameter int LINE_CYC   = 1364,
  parameter int LINES      = 262,
  parameter int VIS_LO     = 224,
  parameter int VIS_HI     = 239,
  parameter int HBLANK_POS = 1096,
  parameter int INIT_POS   = 20,
  parameter int REF_A      = 534,
  parameter int REF_B      = 538,
  parameter int NMI_DELAY  = 12,
  localparam int HW        = $clog2(LINE_CYC),
  localparam int VW        = $clog2(LINES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ilace_i,
  input logic          overscan_i,
  input logic          joy_en_i,
  input logic [HW-1:0] h_cnt_o,
  input logic [VW-1:0] v_cnt_o,
  input logic          hblank_o,
  input logic          line_dma_o,
  input logic          line_end_o,
  input logic          frame_init_o,
  input logic          render_o,
  input logic          refresh_o,
  input logic          stall_o,
  input logic          dma_clear_o,
  input logic          joy_start_o,
  input logic          vblank_o,
  input logic          field_o,
  input logic          nmi_o
);

  logic [VW-1:0] vis;
  assign vis = overscan_i ? VW'(VIS_HI) : VW'(VIS_LO);

  p_hinc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end_o |=> h_cnt_o == $past(h_cnt_o) + HW'(1));

  p_hwrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_end_o |=> h_cnt_o == '0);

  p_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_o) |-> (v_cnt_o == '0 && h_cnt_o == '0));

  p_full_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end_o && (ilace_i || !field_o)) |-> h_cnt_o == HW'(LINE_CYC - 1));

  p_ref_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |-> (h_cnt_o == HW'(REF_A) || h_cnt_o == HW'(REF_B)));

  p_stall_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_o) |-> refresh_o);

  p_stall_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |-> stall_o);

  p_vbl_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank_o) |-> (h_cnt_o == '0 && v_cnt_o == vis + VW'(1) && dma_clear_o));

  p_vbl_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (v_cnt_o == '0) |-> !vblank_o);

  p_nmi_in_vbl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |-> vblank_o);

  p_nmi_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> h_cnt_o == HW'(NMI_DELAY));

  p_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_init_o |-> (v_cnt_o == '0 && h_cnt_o == HW'(INIT_POS)));

  p_joy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    joy_start_o |-> (joy_en_i && h_cnt_o == '0));

  p_hblank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_o |-> h_cnt_o == HW'(HBLANK_POS));

  p_visible_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (line_dma_o || render_o) |-> v_cnt_o <= vis);

endmodule

bind ft_frame_timer ft_frame_timer_chk #(
  .LINE_CYC(LINE_CYC), .LINES(LINES), .VIS_LO(VIS_LO), .VIS_HI(VIS_HI),
  .HBLANK_POS(HBLANK_POS), .INIT_POS(INIT_POS), .REF_A(REF_A), .REF_B(REF_B),
  .NMI_DELAY(NMI_DELAY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ilace_i(ilace_i), .overscan_i(overscan_i),
  .joy_en_i(joy_en_i), .h_cnt_o(h_cnt_o), .v_cnt_o(v_cnt_o),
  .hblank_o(hblank_o), .line_dma_o(line_dma_o), .line_end_o(line_end_o),
  .frame_init_o(frame_init_o), .render_o(render_o), .refresh_o(refresh_o),
  .stall_o(stall_o), .dma_clear_o(dma_clear_o), .joy_start_o(joy_start_o),
  .vblank_o(vblank_o), .field_o(field_o), .nmi_o(nmi_o)
);

// File: tb/test_ft_frame_timer.sv
`timescale 1ns/1ps
module test_ft_frame_timer;

  localparam int L    = 64;
  localparam int D    = 4;
  localparam int N    = 30;
  localparam int VLO  = 20;
  localparam int VHI  = 24;
  localparam int SL   = 26;
  localparam int HB   = 44;
  localparam int HD   = 50;
  localparam int INP  = 2;
  localparam int RP   = 6;
  localparam int RA   = 16;
  localparam int RB   = 20;
  localparam int RLEN = 6;
  localparam int ND   = 12;
  localparam int HW   = $clog2(L);
  localparam int VW   = $clog2(N + 1);
  localparam int FRAMES = 44;

  logic clk = 1'b0;
  logic rst_n;
  logic ilace, ovs, nmi_en, joy_en;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic hblank, line_dma, line_end, frame_init, render, refresh, stall;
  logic dma_clear, joy_start, vblank, field, nmi;

  always #10 clk = ~clk;

  ft_frame_timer #(
    .LINE_CYC(L), .DOT_CYC(D), .LINES(N), .VIS_LO(VLO), .VIS_HI(VHI),
    .SHORT_LINE(SL), .HBLANK_POS(HB), .LINE_DMA_POS(HD), .INIT_POS(INP),
    .RENDER_POS(RP), .REF_A(RA), .REF_B(RB), .REF_LEN(RLEN), .NMI_DELAY(ND)
  ) i_ft_frame_timer (
    .clk(clk), .rst_n(rst_n), .ilace_i(ilace), .overscan_i(ovs),
    .nmi_en_i(nmi_en), .joy_en_i(joy_en), .h_cnt_o(h_cnt), .v_cnt_o(v_cnt),
    .hblank_o(hblank), .line_dma_o(line_dma), .line_end_o(line_end),
    .frame_init_o(frame_init), .render_o(render), .refresh_o(refresh),
    .stall_o(stall), .dma_clear_o(dma_clear), .joy_start_o(joy_start),
    .vblank_o(vblank), .field_o(field), .nmi_o(nmi)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  int  mh, mv, mfld, mphase, mvbl, mnmi, marmed;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (line %0d cyc %0d)", req, what, act, exp, mv, mh);
    end
  endtask

  function automatic int vis_of(input int o);
    return o ? VHI : VLO;
  endfunction

  function automatic int len_of(input int il, input int f, input int v);
    return (!il && f && v == SL) ? L - D : L;   // R4
  endfunction

  function automatic int lines_of(input int il, input int f);
    return (il && !f) ? N + 1 : N;              // R2
  endfunction

  task automatic compare_all();
    int vis, len, rpos;
    vis  = vis_of(ovs);
    len  = len_of(ilace, mfld, mv);
    rpos = mphase ? RB : RA;
    chk("R1", "h_cnt", int'(h_cnt), mh);
    chk("R2", "v_cnt", int'(v_cnt), mv);
    chk("R3", "field", int'(field), mfld);
    chk("R4", "line_end", int'(line_end), int'(mh == len - 1));
    chk("R5", "refresh", int'(refresh), int'(mh == rpos));
    chk("R6", "stall", int'(stall), int'(mh >= rpos && mh < rpos + RLEN));
    chk("R7", "vblank", int'(vblank), mvbl);
    chk("R7", "dma_clear", int'(dma_clear), int'(mh == 0 && mv == vis + 1));
    chk("R8", "nmi", int'(nmi), mnmi);
    chk("R9", "frame_init", int'(frame_init), int'(mh == INP && mv == 0));
    chk("R10", "joy_start", int'(joy_start), int'(joy_en && mh == 0 && mv == vis + 3));
    chk("R11", "hblank", int'(hblank), int'(mh == HB));
    chk("R11", "line_dma", int'(line_dma), int'(mh == HD && mv <= vis));
    chk("R11", "render", int'(render), int'(mh == RP && mv >= 1 && mv <= vis));
  endtask

  task automatic step_model(output bit wrapped);
    int vis, len, nv, nf;
    vis = vis_of(ovs);
    len = len_of(ilace, mfld, mv);
    wrapped = 0;
    if (mh == len - 1) begin
      mh = 0;
      if (mv == lines_of(ilace, mfld) - 1) begin
        nv = 0; nf = mfld ^ 1; wrapped = 1;
        mvbl = 0; mnmi = 0; marmed = 0;
      end else begin
        nv = mv + 1; nf = mfld;
        if (nv == vis + 1) begin mvbl = 1; marmed = nmi_en; end
      end
      if (!(!ilace && nf && nv == SL)) mphase ^= 1;   // R5
      mv = nv; mfld = nf;
    end else begin
      if (marmed && mv == vis + 1 && mh == ND - 1) begin mnmi = 1; marmed = 0; end
      mh = mh + 1;
    end
  endtask

  initial begin
    int frames;
    bit wr;
    void'($urandom(32'd7321));
    rst_n = 0; ilace = 0; ovs = 0; nmi_en = 0; joy_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk("R12", "reset h", int'(h_cnt), 0);
    chk("R12", "reset v", int'(v_cnt), 0);
    chk("R12", "reset field", int'(field), 0);
    chk("R12", "reset vblank", int'(vblank), 0);
    chk("R12", "reset nmi", int'(nmi), 0);
    rst_n = 1;
    mh = 0; mv = 0; mfld = 0; mphase = 0; mvbl = 0; mnmi = 0; marmed = 0;
    frames = 0;
    while (frames < FRAMES) begin
      if (mh == 0 && mv == 0) begin
        case (frames)
          0: begin ilace = 0; ovs = 0; nmi_en = 1; joy_en = 1; end
          1: begin ilace = 0; ovs = 0; nmi_en = 0; joy_en = 0; end  // field 1: short line
          2: begin ilace = 1; ovs = 1; nmi_en = 1; joy_en = 1; end  // long field
          3: begin ilace = 1; ovs = 1; nmi_en = 0; joy_en = 1; end  // no shortening
          4: begin ilace = 0; ovs = 1; nmi_en = 1; joy_en = 0; end
          5: begin ilace = 0; ovs = 1; nmi_en = 1; joy_en = 1; end
          default: begin
            ilace  = 1'($urandom_range(0, 1));
            ovs    = 1'($urandom_range(0, 1));
            nmi_en = 1'($urandom_range(0, 1));
            joy_en = 1'($urandom_range(0, 1));
          end
        endcase
      end else if (mv != vis_of(ovs)) begin
        // NMI enable may wander except on the line it is sampled
        if ($urandom_range(0, 199) == 0) nmi_en = ~nmi_en;
      end
      #1;
      compare_all();
      step_model(wr);
      if (wr) frames++;
      @(negedge clk);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule